// File: doc/BRIEF.md
# Misaligned Data Access Trap Encoder

This block sits next to a processor's load/store unit and inspects every data access in the cycle it is issued. Each access carries an effective address, a size mask (0 for a byte, 1 for a halfword, 3 for a word), a direction flag, the number of the register being loaded or stored, and the current exception-enable state. When any address bit covered by the size mask is set, the access is misaligned. The block then captures the faulting address and a packed status word in registers, and raises a fault pulse.

The status word records four things: a fixed cause code identifying a misaligned data access, the register number, the access direction, and whether the access was word sized. The address and status are captured whether or not exceptions are enabled, so software polling after a masked fault still sees what happened. The trap request is raised only when exceptions are enabled. The pipeline uses the trap request to redirect execution. Performing the access and vectoring the trap are handled elsewhere.

Top module: `unaligned_trap_encoder`

## Requirements
- R1: A valid access is misaligned exactly when the bitwise AND of the address and the size mask is nonzero; `fault_o` is then high for the one cycle after the clock edge that samples the access.
- R2: On a misaligned valid access, `fault_addr_o` holds the access address from the following clock edge onward.
- R3: After a misaligned access, bits 4:0 of `fault_status_o` hold the misaligned-data cause code, 5'h01.
- R4: After a misaligned access, bit 10 of `fault_status_o` equals the write flag (1 = store) and bits 9:5 hold the register number.
- R5: After a misaligned access, bit 11 of `fault_status_o` is 1 only if the size mask was 3 (word); bits 31:12 are 0.
- R6: Address and status are captured even when `exc_en_i` is 0; `trap_req_o` is high after a misaligned access only if `exc_en_i` was 1 for that access.
- R7: An aligned access, or any cycle with `acc_valid_i` low, leaves `fault_addr_o` and `fault_status_o` unchanged and gives no fault or trap in the next cycle.
- R8: While `rst_ni` is low, all outputs are 0.
- R9: `fault_o` and `trap_req_o` are one-cycle pulses per faulting access. Back-to-back faulting accesses give back-to-back pulses, and each cycle carries the latest access's address and status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 32 | Effective address |
| acc_size_i | input | 2 | Size mask: 0 byte, 1 halfword, 3 word |
| acc_write_i | input | 1 | 1 for a store, 0 for a load |
| acc_reg_i | input | 5 | Register number of the load target or store source |
| exc_en_i | input | 1 | Exceptions enabled |
| fault_o | output | 1 | Misaligned access seen last cycle |
| fault_addr_o | output | 32 | Captured faulting address |
| fault_status_o | output | 32 | Captured status word |
| trap_req_o | output | 1 | Trap request pulse |

## Verification
Every cycle, the assertions check the link from a sampled access to the next cycle's outputs. They cover when a fault and a trap must or must not follow, the captured address and each status field, and the hold of the registers after a non-faulting cycle. The bench scenarios are needed for the things that span several cycles or depend on combinations. These are the sticky contents after a masked fault followed by quiet cycles, back-to-back faults overwriting each other, and unusual size masks such as 2. The bench also checks the reset values against its model.

// File: rtl/unaligned_trap_pkg.sv
package unaligned_trap_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned SIZE_W   = 2;
  localparam int unsigned CAUSE_W  = 5;
  localparam int unsigned REG_LSB  = 5;
  localparam int unsigned DIR_BIT  = 10;
  localparam int unsigned WORD_BIT = 11;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'h01;
  localparam logic [SIZE_W-1:0]  SIZE_WORD      = 2'd3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [STAT_W-1:0] status;
  } fault_rec_t;
endpackage

// File: rtl/misalign_detect.sv
module misalign_detect
  import unaligned_trap_pkg::*;
(
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              hit_o
);
  logic [SIZE_W-1:0] low_bits;
  assign low_bits = addr_i[SIZE_W-1:0] & size_i;
  assign hit_o    = valid_i && (low_bits != '0);
endmodule

// File: rtl/status_pack.sv
module status_pack
  import unaligned_trap_pkg::*;
(
  input  logic              write_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    status_o                         = '0;
    status_o[CAUSE_W-1:0]            = CAUSE_MISALIGN;
    status_o[REG_LSB+REG_W-1:REG_LSB] = reg_i;
    status_o[DIR_BIT]                = write_i;
    status_o[WORD_BIT]               = (size_i == SIZE_WORD);
  end
endmodule

// File: rtl/unaligned_trap_encoder.sv
module unaligned_trap_encoder
  import unaligned_trap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [31:0]       acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic              acc_write_i,
  input  logic [4:0]        acc_reg_i,
  input  logic              exc_en_i,
  output logic              fault_o,
  output logic [31:0]       fault_addr_o,
  output logic [31:0]       fault_status_o,
  output logic              trap_req_o
);
  logic        hit;
  logic [31:0] status_d;
  fault_rec_t  rec_q;
  logic        fault_q, trap_q;

  misalign_detect u_detect (
    .valid_i (acc_valid_i),
    .addr_i  (acc_addr_i),
    .size_i  (acc_size_i),
    .hit_o   (hit)
  );

  status_pack u_pack (
    .write_i  (acc_write_i),
    .reg_i    (acc_reg_i),
    .size_i   (acc_size_i),
    .status_o (status_d)
  );

  // capture regardless of enable; only the trap is gated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q   <= '0;
      fault_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      fault_q <= hit;
      trap_q  <= hit && exc_en_i;
      if (hit) begin
        rec_q.addr   <= acc_addr_i;
        rec_q.status <= status_d;
      end
    end
  end

  assign fault_o        = fault_q;
  assign trap_req_o     = trap_q;
  assign fault_addr_o   = rec_q.addr;
  assign fault_status_o = rec_q.status;
endmodule

// File: rtl/unaligned_trap_encoder_chk.sv
module unaligned_trap_encoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        acc_valid_i,
  input logic [31:0] acc_addr_i,
  input logic [1:0]  acc_size_i,
  input logic        acc_write_i,
  input logic [4:0]  acc_reg_i,
  input logic        exc_en_i,
  input logic        fault_o,
  input logic [31:0] fault_addr_o,
  input logic [31:0] fault_status_o,
  input logic        trap_req_o
);
  logic mis;
  assign mis = acc_valid_i && ((acc_addr_i[1:0] & acc_size_i) != 2'b00);

  p_fault_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis |=> fault_o);
  p_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis |=> fault_addr_o == $past(acc_addr_i));
  p_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_status_o[4:0] == 5'h01);
  p_fields_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis |=> (fault_status_o[10] == $past(acc_write_i)) && (fault_status_o[9:5] == $past(acc_reg_i)));
  p_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis |=> (fault_status_o[11] == ($past(acc_size_i) == 2'd3)) && (fault_status_o[31:12] == '0));
  p_trap_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis |=> trap_req_o == $past(exc_en_i));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mis |=> !fault_o && !trap_req_o && $stable(fault_addr_o) && $stable(fault_status_o));
  p_trap_sub_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> fault_o);
endmodule

bind unaligned_trap_encoder unaligned_trap_encoder_chk u_chk (.*);

// File: tb/unaligned_trap_encoder_tb_top.sv
module unaligned_trap_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0, w = 1'b0, en = 1'b0;
  logic [31:0] a = '0;
  logic [1:0]  s = '0;
  logic [4:0]  r = '0;
  logic        f_o, t_o;
  logic [31:0] ea_o, st_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  logic        m_f = 0, m_t = 0;
  logic [31:0] m_ea = 0, m_st = 0;

  always #5 clk = ~clk;

  unaligned_trap_encoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(v), .acc_addr_i(a),
    .acc_size_i(s), .acc_write_i(w), .acc_reg_i(r), .exc_en_i(en),
    .fault_o(f_o), .fault_addr_o(ea_o), .fault_status_o(st_o), .trap_req_o(t_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_f <= 0; m_t <= 0; m_ea <= 0; m_st <= 0;
    end else begin
      int bad;
      bad = v && ((a % 4) & s) != 0;
      m_f <= bad;
      m_t <= bad && en;
      if (bad) begin
        m_ea <= a;
        m_st <= 32'h1 + r * 32 + w * 1024 + ((s == 3) ? 2048 : 0);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1/R7/R9 fault", {31'b0, f_o}, {31'b0, m_f});
    chk("R6/R9 trap", {31'b0, t_o}, {31'b0, m_t});
    chk("R2 addr", ea_o, m_ea);
    chk("R3 cause", {27'b0, st_o[4:0]}, {27'b0, m_st[4:0]});
    chk("R4 dir/reg", {26'b0, st_o[10:5]}, {26'b0, m_st[10:5]});
    chk("R5 word/upper", {11'b0, st_o[31:11]}, {11'b0, m_st[31:11]});
  end

  task automatic acc(logic vv, logic [31:0] aa, logic [1:0] ss, logic ww, logic [4:0] rr, logic ee);
    @(negedge clk);
    v = vv; a = aa; s = ss; w = ww; r = rr; en = ee;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #3;
    chk("R8 reset fault", {31'b0, f_o}, 32'h0);
    chk("R8 reset trap", {31'b0, t_o}, 32'h0);
    chk("R8 reset addr", ea_o, 32'h0);
    chk("R8 reset status", st_o, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    acc(1, 32'h1000_0000, 3, 0, 5'd3, 1);   // R7 aligned word
    acc(1, 32'h1000_0002, 3, 1, 5'd7, 1);   // R1 R2 R4 R5 misaligned word store -> status 0xCE1
    acc(0, 32'h0, 0, 0, 5'd0, 0);
    acc(1, 32'h2000_0001, 1, 0, 5'd31, 0);  // R6 masked halfword load, captured
    acc(0, 32'h0000_0003, 3, 1, 5'd9, 1);   // R7 invalid ignored
    acc(1, 32'h0000_0005, 0, 1, 5'd2, 1);   // R7 byte never misaligned
    acc(1, 32'h0000_0002, 1, 1, 5'd4, 1);   // R7 halfword aligned
    acc(1, 32'h0000_0002, 2, 1, 5'd4, 1);   // R5 mask 2 faults, bit 11 clear
    acc(1, 32'hFFFF_FFFF, 3, 0, 5'd1, 1);   // R9 back-to-back
    acc(1, 32'h0000_0101, 1, 1, 5'd30, 1);
    acc(0, 32'h0, 0, 0, 5'd0, 0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 400; i++)
      acc($urandom_range(0, 3) != 0, $urandom, 2'($urandom_range(0, 3)),
          1'($urandom), 5'($urandom), 1'($urandom));
    acc(0, 32'h0, 0, 0, 5'd0, 0);
    rst_n = 1'b0;                           // R8 async reset mid-run
    #2;
    chk("R8 async reset status", st_o, 32'h0);
    chk("R8 async reset addr", ea_o, 32'h0);
    @(negedge clk);
    finish_run();
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule